// File: doc/BRIEF.md
# Barrier Gate Motor Controller

This block runs the motor of a vehicle entry barrier. An entry push button, two limit sensors (fully down, fully up) and a vehicle-presence sensor come in as raw single-bit signals. Two motor signals go out: a run enable and a direction. Each raw input first passes through a chain of synchronizer flops. A four-state machine then takes the gate through one fixed cycle. It waits for a request, drives the gate up until the upper limit is reached, and stops the motor while a vehicle is still in the gate area. Once that area is clear it drives the gate down until the lower limit is reached.

The same input pattern can mean different things at different points in the cycle. With every input low, the gate may be rising or it may be descending. For this reason the controller keeps its position in the cycle in a state register, which updates on the rising clock edge. A button press that arrives while a cycle is running has no effect and is not stored for later. The state register and the synchronizers clear on a synchronous active-high reset.

Top module: `gate_motor_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the controller goes to the wait-for-request step with `motorOn`=0. It stays there, with the motor off, for as long as the synchronized request is low.
- R2: Each raw input passes through two flops before it reaches the state machine. A request first driven high just after rising edge n gives `motorOn`=1 after edge n+3, and not before.
- R3: While the gate is rising, the outputs are `motorOn`=1 and `motorUp`=1.
- R4: The gate keeps rising until the synchronized upper-limit input is high. The motor then stops (`motorOn`=0), and an upward drive never lasts beyond the third edge after the raw upper-limit input rises.
- R5: After the upper limit, the motor stays off while the synchronized vehicle input is high. Lowering begins on the edge after the vehicle input is seen low.
- R6: While the gate is lowering, the outputs are `motorOn`=1 and `motorUp`=0. When the synchronized lower-limit input is high, the motor stops and the controller returns to waiting for a request. A downward drive never lasts beyond the third edge after the raw lower-limit input rises.
- R7: A request that arrives during raising, holding or lowering is ignored and is not remembered. After the cycle ends, the motor stays off until a new request arrives.
- R8: When `motorOn`=0, `motorUp` is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqBtn | input | 1 | Entry request push button, raw |
| atBottom | input | 1 | Gate fully down sensor, raw |
| atTop | input | 1 | Gate fully up sensor, raw |
| carPresent | input | 1 | Vehicle in gate area sensor, raw |
| motorOn | output | 1 | Motor run enable |
| motorUp | output | 1 | Motor direction, 1 = up |

## Verification
Two functions can fall in the same cycle. A button press can line up with the end of a cycle, so the request lockout meets the limit-sensor stop. A clear vehicle sensor can also meet the upper-limit handshake. The bench provokes the first by pulsing the request during lowering and by random presses throughout. It provokes the second by letting the vehicle sensor toggle at random while the gate rises. A bench-side step model, fed by its own two-deep delay of the raw inputs, judges every cycle. A gate-position counter that drives the limit sensors also checks that the motor never pushes past a limit for longer than the synchronizer latency.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int NUM_SENSE = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAISE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_LOWER = 2'd3
  } gateState_t;

  // synchronized view of the raw inputs
  typedef struct packed {
    logic car;
    logic top;
    logic bottom;
    logic req;
  } senseVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic up;
  } motorCmd_t;
endpackage

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reqRaw,
  input  logic      bottomRaw,
  input  logic      topRaw,
  input  logic      carRaw,
  input  motorCmd_t cmd,
  output senseVec_t sense,
  output logic      motorOn,
  output logic      motorUp
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SENSE-1:0] rawVec;
  logic [NUM_SENSE-1:0] syncVec;

  assign rawVec = {carRaw, topRaw, bottomRaw, reqRaw};

  for (genvar g = 0; g < NUM_SENSE; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk) begin
      if (rst) chainQ <= '0;
      else     chainQ <= {chainQ[LAST-1:0], rawVec[g]};
    end
    assign syncVec[g] = chainQ[LAST];
  end

  assign sense   = senseVec_t'(syncVec);
  // direction is forced low whenever the motor is idle (R8)
  assign motorOn = cmd.run;
  assign motorUp = cmd.run & cmd.up;
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  senseVec_t sense,
  output motorCmd_t cmd
);
  gateState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (sense.req)    stateD = ST_RAISE;
      ST_RAISE: if (sense.top)    stateD = ST_HOLD;
      ST_HOLD:  if (!sense.car)   stateD = ST_LOWER;
      ST_LOWER: if (sense.bottom) stateD = ST_IDLE;
      default:                    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    cmd.run = (stateQ == ST_RAISE) || (stateQ == ST_LOWER);
    cmd.up  = (stateQ == ST_RAISE);
  end

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && !sense.req) |=> (stateQ == ST_IDLE)); // R1
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && sense.req) |=> (stateQ == ST_RAISE)); // R2
  AST_STOP_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RAISE && sense.top) |=> (stateQ == ST_HOLD)); // R4
  AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD && sense.car) |=> (stateQ == ST_HOLD)); // R5
  AST_STOP_AT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOWER && sense.bottom) |=> (stateQ == ST_IDLE)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD || stateQ == ST_LOWER) |=> (stateQ != ST_RAISE)); // R7
endmodule

// File: rtl/gate_motor_ctrl.sv
module gate_motor_ctrl
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic reqBtn,
  input  logic atBottom,
  input  logic atTop,
  input  logic carPresent,
  output logic motorOn,
  output logic motorUp
);
  senseVec_t senseSync;
  motorCmd_t motorCmd;

  gate_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rst(rst),
    .reqRaw(reqBtn), .bottomRaw(atBottom), .topRaw(atTop), .carRaw(carPresent),
    .cmd(motorCmd), .sense(senseSync),
    .motorOn(motorOn), .motorUp(motorUp)
  );

  gate_ctrl uCtl (
    .clk(clk), .rst(rst),
    .sense(senseSync), .cmd(motorCmd)
  );

  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !motorOn |-> !motorUp); // R8
endmodule

// File: tb/sim_gate_motor_ctrl.sv
module sim_gate_motor_ctrl;
  import gate_pkg::*;

  localparam int TRAVEL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqBtn = 1'b0, atBottom = 1'b1, atTop = 1'b0, carPresent = 1'b0;
  logic motorOn, motorUp;

  int compared = 0;
  int mismatched = 0;
  int pos = 0;
  int upCnt = 0;
  int downCnt = 0;
  bit done = 1'b0;

  gateState_t mState = ST_IDLE;
  senseVec_t q1 = '0, q2 = '0;

  always #2 clk = ~clk;  // 250 MHz

  gate_motor_ctrl u0 (
    .clk(clk), .rst(rst), .reqBtn(reqBtn), .atBottom(atBottom),
    .atTop(atTop), .carPresent(carPresent), .motorOn(motorOn), .motorUp(motorUp)
  );

  task automatic check(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expRun(gateState_t s);
    return (s == ST_RAISE) || (s == ST_LOWER);
  endfunction

  function automatic string stepTag(gateState_t s);
    case (s)
      ST_IDLE:  return "R1 idle motor";
      ST_RAISE: return "R3 raise motor";
      ST_HOLD:  return "R5 hold motor";
      default:  return "R6 lower motor";
    endcase
  endfunction

  // step model: decides from its own two-deep delayed inputs
  always @(posedge clk) begin
    if (rst) begin
      mState <= ST_IDLE; q1 <= '0; q2 <= '0;
    end else begin
      case (mState)
        ST_IDLE:  if (q2.req)    mState <= ST_RAISE;
        ST_RAISE: if (q2.top)    mState <= ST_HOLD;
        ST_HOLD:  if (!q2.car)   mState <= ST_LOWER;
        default:  if (q2.bottom) mState <= ST_IDLE;
      endcase
      q2 <= q1;
      q1 <= '{car: carPresent, top: atTop, bottom: atBottom, req: reqBtn};
    end
  end

  // per-cycle compare and gate-position model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(stepTag(mState), motorOn, expRun(mState));
      check("R8 direction", motorUp, mState == ST_RAISE);
      if (motorOn && motorUp && upCnt > 2)
        check("R4 drive past upper limit", 1'b1, 1'b0);
      if (motorOn && !motorUp && downCnt > 2)
        check("R6 drive past lower limit", 1'b1, 1'b0);
    end
    if (motorOn && motorUp && pos < TRAVEL) pos++;
    else if (motorOn && !motorUp && pos > 0) pos--;
    atTop    = (pos == TRAVEL);
    atBottom = (pos == 0);
    upCnt    = atTop ? upCnt + 1 : 0;
    downCnt  = atBottom ? downCnt + 1 : 0;
  end

  task automatic waitStep(gateState_t s);
    for (int i = 0; i < 500 && mState != s; i++) @(negedge clk);
    if (mState != s) check("step reached", 1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check("R1 reset motor off", motorOn, 1'b0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 idle no request", motorOn, 1'b0);

    // R2 latency of a single request pulse
    reqBtn = 1'b1; carPresent = 1'b1;
    @(negedge clk); reqBtn = 1'b0;
    check("R2 edge n+1", motorOn, 1'b0);
    @(negedge clk);
    check("R2 edge n+2", motorOn, 1'b0);
    @(negedge clk);
    check("R2 edge n+3 run", motorOn, 1'b1);
    check("R3 direction up", motorUp, 1'b1);

    // R4 / R5: reach top, hold while vehicle remains
    waitStep(ST_HOLD);
    repeat (20) begin
      @(negedge clk);
      check("R5 vehicle present motor off", motorOn, 1'b0);
    end
    carPresent = 1'b0;

    // R7: press during lowering, then nothing after the cycle ends
    waitStep(ST_LOWER);
    @(negedge clk);
    reqBtn = 1'b1;
    @(negedge clk); reqBtn = 1'b0;
    waitStep(ST_IDLE);
    repeat (30) begin
      @(negedge clk);
      check("R7 request during cycle ignored", motorOn, 1'b0);
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reqBtn = ($urandom % 20) == 0;
      if (($urandom % 10) == 0) carPresent = ~carPresent;
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule